// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Protected Low Entries

This block is a fully associative address translation cache. Every entry describes two neighbouring virtual pages, an even one and an odd one, that share one virtual tag, one address space identifier and one page size. Each half has its own physical frame number, its own attribute bits and its own valid flag. The page size is chosen per entry, from 4 KB up to 16 MB in factors of four. A lookup presents a 32-bit virtual address and the current address space identifier. One clock later the block returns a 36-bit physical address, the attribute bits of the selected half, and match, hit and multiple-match flags.

Software-side refill logic loads entries through a single write port. The port writes either at an index that the caller supplies or at the index held by a free-running down-counter. A programmable boundary, the protected count, keeps the lowest-numbered entries out of the counter's range, so mappings placed there are never displaced by counter-directed refills.

Top module: `paired_tlb`

## Requirements
- R1: While reset is asserted and after it is released, every half of every entry is invalid. No lookup reports a hit. The victim index is ENTRIES-1 (47), the protected count is 0 and no response is flagged.
- R2: An entry matches when the virtual address bits above the pair-select bit equal its stored tag. Tag bits covered by the entry's page size are ignored. The lookup identifier must also equal the entry's identifier, unless the entry's global flag is set.
- R3: The half is selected by virtual address bit 12+2*size: 0 picks the even half and 1 picks the odd half. The physical address takes its bits above the page offset from the selected frame number and its offset bits, 12+2*size of them, from the virtual address.
- R4: The size code picks the page size 4 KB << (2*code): 0 is 4 KB, 1 is 16 KB, 2 is 64 KB, 3 is 256 KB, 4 is 1 MB, 5 is 4 MB and 6 is 16 MB. A code of 7 is stored as 6.
- R5: A lookup that matches an entry whose selected half is invalid reports match=1 and hit=0, with a zero address and zero attributes.
- R6: When more than one entry matches, the multiple-match flag is set and the result is taken from the lowest-numbered matching entry.
- R7: The lookup result appears on the response outputs exactly one clock after the request, and rsp_valid marks it.
- R8: A write with wr_random=0 loads the entry at wr_index. The entry holds the tag, identifier, global flag, size and both halves, and later lookups see it.
- R9: A write with wr_random=1 loads the entry whose number victim_index shows in the cycle of the write.
- R10: The victim index drops by one each clock. In the clock after it equals the protected count, it returns to 47. A write to the protected count sets it to 47 in the next cycle. Protected count values above 47 are stored as 47.
- R11: The victim index never falls below the protected count, so entries below that count are never replaced by a counter-directed write.
- R12: On a hit, rsp_attr carries the attribute bits of the selected half, and rsp_index gives the entry number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address space identifier |
| wr_en | input | 1 | Entry write strobe |
| wr_random | input | 1 | 1: write at victim index, 0: at wr_index |
| wr_index | input | IDX_W | Explicit write index |
| wr_vtag | input | 19 | Virtual tag (address bits 31:13) |
| wr_asid | input | ASID_W | Entry identifier |
| wr_global | input | 1 | Ignore identifier on match |
| wr_size | input | 3 | Page size code |
| wr_pfn_even | input | PA_W-12 | Even half frame number |
| wr_attr_even | input | ATTR_W | Even half attributes |
| wr_valid_even | input | 1 | Even half valid |
| wr_pfn_odd | input | PA_W-12 | Odd half frame number |
| wr_attr_odd | input | ATTR_W | Odd half attributes |
| wr_valid_odd | input | 1 | Odd half valid |
| prot_we | input | 1 | Protected count write strobe |
| prot_din | input | IDX_W | New protected count |
| victim_index | output | IDX_W | Current replacement index |
| rsp_valid | output | 1 | Response present |
| rsp_match | output | 1 | Some entry matched |
| rsp_hit | output | 1 | Matched and selected half valid |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_paddr | output | PA_W | Physical address |
| rsp_attr | output | ATTR_W | Attributes of selected half |
| rsp_index | output | IDX_W | Number of the entry used |

## Verification
On every cycle, the assertions check the victim counter's range and its step, reload and reset-on-write behaviour. They also check that flags stay consistent with one another (a hit or a multiple match implies a match) and that each response follows its request by exactly one cycle. Address formation for each page size, pair-half selection, identifier and global handling, invalid halves, the choice of the lowest entry under multiple matches, and the survival of protected entries across many counter-directed refills all depend on stored contents. Only the bench's scenarios, compared against its own translation model, can show these.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int VA_W       = 32;
   localparam int PAGE_SHIFT = 12;
   localparam int VTAG_W     = VA_W - PAGE_SHIFT - 1;
   localparam int SIZE_W     = 3;
   localparam int MASK_W     = 12;
   localparam logic [SIZE_W-1:0] SIZE_MAX = 3'd6;

   // Tag bits ignored for a page size code: two per step of 4x.
   function automatic logic [MASK_W-1:0] size_mask(input logic [SIZE_W-1:0] code);
      logic [MASK_W-1:0] m;
      m = '0;
      for (int i = 0; i < MASK_W / 2; i++) begin
         if (SIZE_W'(i) < code) m[2*i +: 2] = 2'b11;
      end
      return m;
   endfunction

   function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] code);
      return (code > SIZE_MAX) ? SIZE_MAX : code;
   endfunction
endpackage

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr #(
   parameter int ENTRIES = 48,
   parameter int IDX_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prot_we,
   input  logic [IDX_W-1:0] prot_din,
   output logic [IDX_W-1:0] victim_idx,
   output logic [IDX_W-1:0] prot_q
);
   localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         victim_idx <= TOP;
         prot_q     <= '0;
      end else if (prot_we) begin
         prot_q     <= (prot_din > TOP) ? TOP : prot_din;
         victim_idx <= TOP;
      end else if (victim_idx <= prot_q) begin
         victim_idx <= TOP;
      end else begin
         victim_idx <= victim_idx - 1'b1;
      end
   end

   a_r11_never_below_protected : assert property (@(posedge clk) disable iff (!rst_n)
      (victim_idx >= prot_q) && (victim_idx <= TOP));

   a_r10_step_down : assert property (@(posedge clk) disable iff (!rst_n)
      (!prot_we && victim_idx > prot_q) |=> (victim_idx == $past(victim_idx) - 1'b1));

   a_r10_reload_at_bound : assert property (@(posedge clk) disable iff (!rst_n)
      (!prot_we && victim_idx == prot_q) |=> (victim_idx == TOP));

   a_r10_write_restarts : assert property (@(posedge clk) disable iff (!rst_n)
      prot_we |=> (victim_idx == TOP));
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 48,
   parameter int IDX_W   = 6,
   parameter int ASID_W  = 8,
   parameter int PA_W    = 36,
   parameter int ATTR_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [VTAG_W-1:0]       wr_vtag,
   input  logic [ASID_W-1:0]       wr_asid,
   input  logic                    wr_global,
   input  logic [SIZE_W-1:0]       wr_size,
   input  logic [PA_W-13:0]        wr_pfn_even,
   input  logic [ATTR_W-1:0]       wr_attr_even,
   input  logic                    wr_valid_even,
   input  logic [PA_W-13:0]        wr_pfn_odd,
   input  logic [ATTR_W-1:0]       wr_attr_odd,
   input  logic                    wr_valid_odd,
   input  logic [VA_W-1:0]         lk_vaddr,
   input  logic [ASID_W-1:0]       lk_asid,
   output logic [ENTRIES-1:0]      m_match,
   output logic [ENTRIES-1:0]      m_valid,
   output logic [PA_W-1:0]         m_paddr [ENTRIES],
   output logic [ATTR_W-1:0]       m_attr  [ENTRIES]
);
   localparam int PFN_W = PA_W - PAGE_SHIFT;

   logic [VTAG_W-1:0] e_vtag  [ENTRIES];
   logic [ASID_W-1:0] e_asid  [ENTRIES];
   logic              e_glob  [ENTRIES];
   logic [SIZE_W-1:0] e_size  [ENTRIES];
   logic [PFN_W-1:0]  e_pfn   [ENTRIES][2];
   logic [ATTR_W-1:0] e_attr  [ENTRIES][2];
   logic              e_valid [ENTRIES][2];

   always_ff @(posedge clk) begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (!rst_n) begin
            e_vtag[i]     <= '0;
            e_asid[i]     <= '0;
            e_glob[i]     <= 1'b0;
            e_size[i]     <= '0;
            e_pfn[i][0]   <= '0;
            e_pfn[i][1]   <= '0;
            e_attr[i][0]  <= '0;
            e_attr[i][1]  <= '0;
            e_valid[i][0] <= 1'b0;
            e_valid[i][1] <= 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            e_vtag[i]     <= wr_vtag;
            e_asid[i]     <= wr_asid;
            e_glob[i]     <= wr_global;
            e_size[i]     <= clamp_size(wr_size);
            e_pfn[i][0]   <= wr_pfn_even;
            e_pfn[i][1]   <= wr_pfn_odd;
            e_attr[i][0]  <= wr_attr_even;
            e_attr[i][1]  <= wr_attr_odd;
            e_valid[i][0] <= wr_valid_even;
            e_valid[i][1] <= wr_valid_odd;
         end
      end
   end

   logic [VTAG_W-1:0] lk_vtag;
   assign lk_vtag = lk_vaddr[VA_W-1 -: VTAG_W];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic [MASK_W-1:0] mask;
      logic [VTAG_W-1:0] tag_care;
      logic [PA_W-1:0]   off_mask;
      logic              half;
      always_comb begin
         mask      = size_mask(e_size[g]);
         tag_care  = ~VTAG_W'(mask);
         off_mask  = PA_W'({mask, {PAGE_SHIFT{1'b1}}});
         half      = lk_vaddr[PAGE_SHIFT + 2 * int'(e_size[g])];
         m_match[g] = (((lk_vtag ^ e_vtag[g]) & tag_care) == '0) &&
                      (e_glob[g] || (e_asid[g] == lk_asid));
         m_valid[g] = e_valid[g][half];
         m_attr[g]  = e_attr[g][half];
         m_paddr[g] = ({e_pfn[g][half], {PAGE_SHIFT{1'b0}}} & ~off_mask) |
                      (PA_W'(lk_vaddr) & off_mask);
      end
   end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve #(
   parameter int ENTRIES = 48,
   parameter int IDX_W   = 6,
   parameter int PA_W    = 36,
   parameter int ATTR_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [ENTRIES-1:0] m_match,
   input  logic [ENTRIES-1:0] m_valid,
   input  logic [PA_W-1:0]    m_paddr [ENTRIES],
   input  logic [ATTR_W-1:0]  m_attr  [ENTRIES],
   output logic               rsp_valid,
   output logic               rsp_match,
   output logic               rsp_hit,
   output logic               rsp_multi,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [ATTR_W-1:0]  rsp_attr,
   output logic [IDX_W-1:0]   rsp_index
);
   logic [IDX_W-1:0] sel;
   logic             any;
   logic             many;

   always_comb begin
      sel  = '0;
      any  = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (m_match[i]) begin
            sel = IDX_W'(i);
            any = 1'b1;
         end
      end
      many = ($countones(m_match) > 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_match <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_multi <= 1'b0;
         rsp_paddr <= '0;
         rsp_attr  <= '0;
         rsp_index <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_match <= lk_valid && any;
         rsp_multi <= lk_valid && many;
         rsp_index <= sel;
         rsp_hit   <= lk_valid && any && m_valid[sel];
         rsp_paddr <= (lk_valid && any && m_valid[sel]) ? m_paddr[sel] : '0;
         rsp_attr  <= (lk_valid && any && m_valid[sel]) ? m_attr[sel]  : '0;
      end
   end

   a_r7_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   a_r7_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);
   a_r5_hit_needs_match : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_match);
   a_r6_multi_needs_match : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_multi |-> rsp_match);
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 48,
   parameter int IDX_W   = $clog2(ENTRIES),
   parameter int ASID_W  = 8,
   parameter int PA_W    = 36,
   parameter int ATTR_W  = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lk_valid,
   input  logic [31:0]           lk_vaddr,
   input  logic [ASID_W-1:0]     lk_asid,
   input  logic                  wr_en,
   input  logic                  wr_random,
   input  logic [IDX_W-1:0]      wr_index,
   input  logic [18:0]           wr_vtag,
   input  logic [ASID_W-1:0]     wr_asid,
   input  logic                  wr_global,
   input  logic [2:0]            wr_size,
   input  logic [PA_W-13:0]      wr_pfn_even,
   input  logic [ATTR_W-1:0]     wr_attr_even,
   input  logic                  wr_valid_even,
   input  logic [PA_W-13:0]      wr_pfn_odd,
   input  logic [ATTR_W-1:0]     wr_attr_odd,
   input  logic                  wr_valid_odd,
   input  logic                  prot_we,
   input  logic [IDX_W-1:0]      prot_din,
   output logic [IDX_W-1:0]      victim_index,
   output logic                  rsp_valid,
   output logic                  rsp_match,
   output logic                  rsp_hit,
   output logic                  rsp_multi,
   output logic [PA_W-1:0]       rsp_paddr,
   output logic [ATTR_W-1:0]     rsp_attr,
   output logic [IDX_W-1:0]      rsp_index
);
   if (ENTRIES < 2 || ENTRIES > (1 << IDX_W)) begin : g_bad_entries
      $error("paired_tlb: ENTRIES does not fit IDX_W");
   end
   if (PA_W < PAGE_SHIFT + 2 * MASK_W) begin : g_bad_pa
      $error("paired_tlb: PA_W too narrow for 16MB pages");
   end

   logic [IDX_W-1:0]   prot_q;
   logic [IDX_W-1:0]   wr_slot;
   logic [ENTRIES-1:0] m_match;
   logic [ENTRIES-1:0] m_valid;
   logic [PA_W-1:0]    m_paddr [ENTRIES];
   logic [ATTR_W-1:0]  m_attr  [ENTRIES];

   assign wr_slot = wr_random ? victim_index : wr_index;

   tlb_victim_ctr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .prot_we(prot_we), .prot_din(prot_din),
      .victim_idx(victim_index), .prot_q(prot_q)
   );

   tlb_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .ASID_W(ASID_W),
                     .PA_W(PA_W), .ATTR_W(ATTR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_slot),
      .wr_vtag(wr_vtag), .wr_asid(wr_asid), .wr_global(wr_global),
      .wr_size(wr_size), .wr_pfn_even(wr_pfn_even), .wr_attr_even(wr_attr_even),
      .wr_valid_even(wr_valid_even), .wr_pfn_odd(wr_pfn_odd),
      .wr_attr_odd(wr_attr_odd), .wr_valid_odd(wr_valid_odd),
      .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
      .m_match(m_match), .m_valid(m_valid), .m_paddr(m_paddr), .m_attr(m_attr)
   );

   tlb_resolve #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PA_W(PA_W),
                 .ATTR_W(ATTR_W)) u_resolve (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
      .m_match(m_match), .m_valid(m_valid), .m_paddr(m_paddr), .m_attr(m_attr),
      .rsp_valid(rsp_valid), .rsp_match(rsp_match), .rsp_hit(rsp_hit),
      .rsp_multi(rsp_multi), .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr),
      .rsp_index(rsp_index)
   );

   a_r9_random_slot_protected : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_random) |-> (wr_slot >= prot_q));
endmodule

// File: tb/paired_tlb_tb.sv
module paired_tlb_tb;
   localparam int E = 48;
   localparam int IW = 6;

   logic clk = 0, rst_n = 0;
   always #10 clk = ~clk;

   logic lk_valid = 0; logic [31:0] lk_vaddr = 0; logic [7:0] lk_asid = 0;
   logic wr_en = 0, wr_random = 0, wr_global = 0;
   logic [IW-1:0] wr_index = 0; logic [18:0] wr_vtag = 0; logic [7:0] wr_asid = 0;
   logic [2:0] wr_size = 0;
   logic [23:0] wr_pfn_even = 0, wr_pfn_odd = 0;
   logic [2:0] wr_attr_even = 0, wr_attr_odd = 0;
   logic wr_valid_even = 0, wr_valid_odd = 0;
   logic prot_we = 0; logic [IW-1:0] prot_din = 0;
   logic [IW-1:0] victim_index, rsp_index;
   logic rsp_valid, rsp_match, rsp_hit, rsp_multi;
   logic [35:0] rsp_paddr; logic [2:0] rsp_attr;

   paired_tlb u_dut (.*);

   int errors = 0, checks = 0;
   bit finished = 0;

   // reference model of stored entries
   logic [18:0] m_tag [E]; logic [7:0] m_asid [E]; logic m_g [E]; int m_sz [E];
   logic [23:0] m_pfn [E][2]; logic [2:0] m_attr [E][2]; logic m_v [E][2];

   typedef struct { logic match, hit, multi; logic [35:0] pa; logic [2:0] attr;
                    int idx; string req; } exp_t;
   exp_t sbq[$];

   task automatic check(input bit ok, input string req, input string msg);
      checks++;
      if (!ok) begin errors++; $display("FAIL %s: %s", req, msg); end
   endtask

   task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input string req);
      exp_t x; int cnt; bit got;
      x.match = 0; x.hit = 0; x.multi = 0; x.pa = 0; x.attr = 0; x.idx = 0; x.req = req;
      cnt = 0; got = 0;
      for (int i = 0; i < E; i++) begin
         logic [18:0] care; int h;
         care = ~19'((1 << (2 * m_sz[i])) - 1);
         if ((((va[31:13] ^ m_tag[i]) & care) == 0) && (m_g[i] || m_asid[i] == asid)) begin
            cnt++;
            if (!got) begin
               logic [35:0] om;
               got = 1; x.idx = i;
               h = va[12 + 2 * m_sz[i]];
               om = (36'(1) << (12 + 2 * m_sz[i])) - 1;
               if (m_v[i][h]) begin
                  x.hit = 1; x.attr = m_attr[i][h];
                  x.pa = ({m_pfn[i][h], 12'h000} & ~om) | ({4'h0, va} & om);
               end
            end
         end
      end
      x.match = got; x.multi = (cnt > 1);
      lk_valid = 1; lk_vaddr = va; lk_asid = asid;
      sbq.push_back(x);
      @(negedge clk);
      lk_valid = 0;
   endtask

   task automatic write(input bit rnd, input int idx, input logic [31:0] va,
                        input logic [7:0] asid, input bit g, input logic [2:0] sz,
                        input logic [23:0] pe, input logic [2:0] ae, input bit ve,
                        input logic [23:0] po, input logic [2:0] ao, input bit vo,
                        output int used);
      used = rnd ? int'(victim_index) : idx;
      wr_en = 1; wr_random = rnd; wr_index = IW'(idx); wr_vtag = va[31:13];
      wr_asid = asid; wr_global = g; wr_size = sz;
      wr_pfn_even = pe; wr_attr_even = ae; wr_valid_even = ve;
      wr_pfn_odd = po; wr_attr_odd = ao; wr_valid_odd = vo;
      m_tag[used] = va[31:13]; m_asid[used] = asid; m_g[used] = g;
      m_sz[used] = (sz > 6) ? 6 : int'(sz);
      m_pfn[used][0] = pe; m_attr[used][0] = ae; m_v[used][0] = ve;
      m_pfn[used][1] = po; m_attr[used][1] = ao; m_v[used][1] = vo;
      @(negedge clk);
      wr_en = 0; wr_random = 0;
   endtask

   task automatic set_prot(input int v);
      prot_we = 1; prot_din = IW'(v);
      @(negedge clk);
      prot_we = 0;
   endtask

   // monitor: pops expected items as responses appear
   initial begin
      forever begin
         @(negedge clk);
         if (rsp_valid && rst_n) begin
            if (sbq.size() == 0) check(0, "R7", "response with no request pending");
            else begin
               exp_t x; x = sbq.pop_front();
               check(rsp_match == x.match && rsp_hit == x.hit && rsp_multi == x.multi,
                     x.req, $sformatf("flags m/h/x act %b%b%b exp %b%b%b",
                     rsp_match, rsp_hit, rsp_multi, x.match, x.hit, x.multi));
               check(rsp_paddr == x.pa && rsp_attr == x.attr, x.req,
                     $sformatf("pa/attr act %h/%0d exp %h/%0d", rsp_paddr, rsp_attr, x.pa, x.attr));
               if (x.match)
                  check(int'(rsp_index) == x.idx, x.req,
                        $sformatf("index act %0d exp %0d", rsp_index, x.idx));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: act timeout exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int u;
      for (int i = 0; i < E; i++) begin
         m_tag[i] = 0; m_asid[i] = 0; m_g[i] = 0; m_sz[i] = 0;
         for (int h = 0; h < 2; h++) begin m_pfn[i][h] = 0; m_attr[i][h] = 0; m_v[i][h] = 0; end
      end
      repeat (3) @(negedge clk);
      check(victim_index == 6'd47, "R1", $sformatf("victim act %0d exp 47", victim_index));
      check(rsp_valid == 0, "R1", $sformatf("rsp_valid act %b exp 0", rsp_valid));
      rst_n = 1;
      @(negedge clk);
      lookup(32'h0040_0123, 8'd5, "R1");
      lookup(32'h7654_3210, 8'd0, "R1");
      check(rsp_valid == 1, "R7", $sformatf("rsp_valid act %b exp 1", rsp_valid));
      @(negedge clk);
      check(rsp_valid == 0, "R7", $sformatf("rsp_valid idle act %b exp 0", rsp_valid));

      // R8/R3/R12: 4K pair, ASID 5
      write(0, 0, 32'h0040_0000, 8'd5, 0, 3'd0, 24'h012345, 3'd3, 1, 24'h054321, 3'd5, 1, u);
      lookup(32'h0040_0123, 8'd5, "R3_even");
      lookup(32'h0040_1ABC, 8'd5, "R12_odd_attr");
      lookup(32'h0040_0123, 8'd6, "R2_asid_miss");
      // R4/R5/R2: global 16M entry, odd half invalid
      write(0, 1, 32'h4000_0000, 8'd1, 1, 3'd6, 24'h0AB000, 3'd2, 1, 24'h0CD000, 3'd4, 0, u);
      lookup(32'h40AB_CDEF, 8'd9, "R2_global");
      lookup(32'h4100_0010, 8'd9, "R5_invalid_half");
      // R4: code 7 behaves as 16M
      write(0, 2, 32'h8000_0000, 8'd5, 0, 3'd7, 24'h111000, 3'd1, 1, 24'h222000, 3'd6, 1, u);
      lookup(32'h8123_4567, 8'd5, "R4_clamp");
      lookup(32'h80FF_FFFF, 8'd5, "R4_clamp_even");
      // R4: 64K page, select bit 16
      write(0, 3, 32'h0100_0000, 8'd5, 0, 3'd2, 24'h0AAAA0, 3'd7, 1, 24'h0BBBB0, 3'd0, 1, u);
      lookup(32'h0101_2345, 8'd5, "R4_64k_odd");
      lookup(32'h0100_F00D, 8'd5, "R4_64k_even");
      // R6: duplicate mapping, lowest index wins
      write(0, 11, 32'h2000_0000, 8'd5, 0, 3'd0, 24'h000B11, 3'd1, 1, 24'h000B12, 3'd1, 1, u);
      write(0, 10, 32'h2000_0000, 8'd5, 0, 3'd0, 24'h000A10, 3'd2, 1, 24'h000A11, 3'd2, 1, u);
      lookup(32'h2000_0044, 8'd5, "R6_multi");
      repeat (2) @(negedge clk);

      // R10: counter sequence with protected count 8
      set_prot(8);
      for (int k = 0; k <= 40; k++) begin
         int ev; ev = (k <= 39) ? 47 - k : 47;
         check(int'(victim_index) == ev, "R10",
               $sformatf("victim act %0d exp %0d", victim_index, ev));
         @(negedge clk);
      end
      // R10: protected count above top is clamped
      set_prot(63);
      repeat (3) begin
         check(victim_index == 6'd47, "R10_clamp", $sformatf("victim act %0d exp 47", victim_index));
         @(negedge clk);
      end

      // R9/R11: counter-directed writes with 4 protected entries
      set_prot(4);
      for (int n = 0; n < 30; n++) begin
         repeat (n % 5) begin
            check(victim_index >= 6'd4, "R11", $sformatf("victim act %0d exp >=4", victim_index));
            @(negedge clk);
         end
         write(1, 0, 32'h3000_0000 + (n << 13) * 2, 8'd5, 0, 3'd0,
               24'h0C0000 + 24'(n), 3'd1, 1, 24'h0D0000 + 24'(n), 3'd2, 1, u);
         check(u >= 4, "R11", $sformatf("random slot act %0d exp >=4", u));
         lookup(32'h3000_0010 + (n << 13) * 2, 8'd5, "R9_random");
      end
      lookup(32'h0040_0123, 8'd5, "R11_protected_kept");
      lookup(32'h40AB_CDEF, 8'd9, "R11_protected_kept");
      repeat (3) @(negedge clk);
      check(sbq.size() == 0, "R7", $sformatf("pending act %0d exp 0", sbq.size()));
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule